// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block runs a linked chain of 64-bit scatter-gather descriptors on behalf of an SD host DMA engine. Software writes the byte address of the first descriptor into a base register and pulses a start input. The walker then reads descriptors one at a time over a simple word read port. Each descriptor is two words: an attribute word followed by an address word.

Each descriptor carries an action. A transfer descriptor is handed to the data mover as an address and a byte count, and the walker waits for the mover to report completion. A link descriptor redirects the walker to a new descriptor address. A no-op descriptor is skipped. The walker stops after the descriptor that carries the end flag. It raises a one-cycle interrupt event for every descriptor that asks for one. A descriptor that is not marked valid, or that has reserved bits set, ends the run with a one-cycle error event.

Top module: `adma_walk`

## Requirements
- R1: Every descriptor is read as the attribute word at the current pointer followed by the address word at pointer+4. `rd_addr` stays stable while `rd_req` waits for `rd_ack`.
- R2: For an action field (attribute bits 5:4) of 2, the walker raises `mv_valid` with `mv_addr` equal to the address word and `mv_len` equal to attribute bits 31:16.
- R3: A transfer whose length field is 0 is issued with `mv_len` = 65536.
- R4: An action of 0 or 1 moves no data, and the next descriptor is fetched from pointer+8.
- R5: An action of 3 moves no data, and the next descriptor is fetched from the address word.
- R6: When attribute bit 1 (end) is set, that descriptor is the last one processed. `busy` falls once its action is complete, and this holds for link descriptors too.
- R7: When attribute bit 2 (interrupt) is set, `irq_pulse` is high for exactly one cycle once that descriptor's action completes. For a transfer, that point is the accepted `mv_done`.
- R8: A descriptor with attribute bit 0 (valid) clear, or with any of attribute bits 15:6 or bit 3 set, moves no data. It pulses `err_pulse` for one cycle and drops `busy`.
- R9: `mv_valid` and its address and length hold until `mv_done`. No descriptor read is issued while a transfer is outstanding.
- R10: A `start` pulse while `busy` is high has no effect on the running chain.
- R11: After reset `busy`, `rd_req`, `mv_valid`, `irq_pulse` and `err_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin walking the chain at `base_addr` |
| base_addr | input | ADDR_W | Byte address of the first descriptor |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | ADDR_W | Byte address of the word being read |
| rd_ack | input | 1 | Read data valid, accepts the request |
| rd_data | input | 32 | Read data word |
| mv_valid | output | 1 | Transfer command outstanding to the data mover |
| mv_addr | output | ADDR_W | Transfer buffer address |
| mv_len | output | LEN_W+1 | Transfer byte count |
| mv_done | input | 1 | Data mover finished the outstanding transfer |
| busy | output | 1 | Chain in progress |
| irq_pulse | output | 1 | One-cycle DMA interrupt event |
| err_pulse | output | 1 | One-cycle descriptor error event |

## Verification
The bench builds the walker with ADDR_W = 32 and LEN_W = 16. With a 16-bit length field, both a 4096-byte transfer and the zero-means-65536 case can be reached. The full 32-bit address words, taken from small descriptor regions of a word memory model, show that link targets and transfer addresses pass through unchanged. The chains mix transfers, skips, links, invalid and malformed descriptors, an end flag on a link, and a restart pulse issued mid-chain.

// File: rtl/adma_walk_pkg.sv
package adma_walk_pkg;
  localparam int WORD_W   = 32;
  localparam int BIT_VLD  = 0;
  localparam int BIT_LAST = 1;
  localparam int BIT_INT  = 2;
  localparam int ACT_LSB  = 4;
  localparam int LEN_LSB  = 16;

  typedef enum logic [1:0] {
    ACT_SKIP = 2'd0,
    ACT_RSVD = 2'd1,
    ACT_MOVE = 2'd2,
    ACT_JUMP = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    W_IDLE,
    W_FETCH,
    W_MOVE
  } walk_st_e;
endpackage

// File: rtl/adma_desc_fetch.sv
module adma_desc_fetch #(
  parameter int ADDR_W = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              go,
  input  logic [ADDR_W-1:0]                 ptr,
  output logic                              rd_req,
  output logic [ADDR_W-1:0]                 rd_addr,
  input  logic                              rd_ack,
  input  logic [adma_walk_pkg::WORD_W-1:0]  rd_data,
  output logic                              done,
  output logic [adma_walk_pkg::WORD_W-1:0]  attr_q,
  output logic [adma_walk_pkg::WORD_W-1:0]  addr_q
);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(adma_walk_pkg::WORD_W / 8);

  typedef enum logic [1:0] {F_IDLE, F_ATTR, F_ADDR} f_st_e;
  f_st_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= F_IDLE;
      rd_req  <= 1'b0;
      rd_addr <= '0;
      done    <= 1'b0;
      attr_q  <= '0;
      addr_q  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        F_IDLE: if (go) begin
          rd_req  <= 1'b1;
          rd_addr <= ptr;
          st      <= F_ATTR;
        end
        F_ATTR: if (rd_ack) begin
          attr_q  <= rd_data;
          rd_addr <= rd_addr + WORD_STEP;
          st      <= F_ADDR;
        end
        F_ADDR: if (rd_ack) begin
          addr_q <= rd_data;
          rd_req <= 1'b0;
          done   <= 1'b1;
          st     <= F_IDLE;
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  // R1
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  // R1
  rd_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_ack && !done && $past(go)) |=> (rd_req && rd_addr == $past(rd_addr) + WORD_STEP));
endmodule

// File: rtl/adma_desc_decode.sv
module adma_desc_decode #(
  parameter int LEN_W = 16
) (
  input  logic [adma_walk_pkg::WORD_W-1:0] attr,
  output logic                             ok,
  output logic                             last,
  output logic                             intr,
  output adma_walk_pkg::act_e              act,
  output logic [LEN_W:0]                   len
);
  import adma_walk_pkg::*;

  localparam int RSV_LO = ACT_LSB + 2;
  localparam int RSV_W  = LEN_LSB - RSV_LO;

  logic [LEN_W-1:0] len_f;
  logic             rsvd;

  always_comb begin
    len_f = attr[LEN_LSB +: LEN_W];
    rsvd  = (|attr[RSV_LO +: RSV_W]) | attr[BIT_INT + 1];
    ok    = attr[BIT_VLD] && !rsvd;
    last  = attr[BIT_LAST];
    intr  = attr[BIT_INT];
    act   = act_e'(attr[ACT_LSB +: 2]);
    len   = (len_f == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, len_f};
  end
endmodule

// File: rtl/adma_walk.sv
module adma_walk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start,
  input  logic [ADDR_W-1:0]                 base_addr,
  output logic                              rd_req,
  output logic [ADDR_W-1:0]                 rd_addr,
  input  logic                              rd_ack,
  input  logic [adma_walk_pkg::WORD_W-1:0]  rd_data,
  output logic                              mv_valid,
  output logic [ADDR_W-1:0]                 mv_addr,
  output logic [LEN_W:0]                    mv_len,
  input  logic                              mv_done,
  output logic                              busy,
  output logic                              irq_pulse,
  output logic                              err_pulse
);
  import adma_walk_pkg::*;

  localparam logic [ADDR_W-1:0] DESC_STEP = ADDR_W'(2 * WORD_W / 8);

  walk_st_e            st;
  logic [ADDR_W-1:0]   ptr;
  logic                fetch_go;
  logic                f_done;
  logic [WORD_W-1:0]   attr_q;
  logic [WORD_W-1:0]   addr_q;
  logic                d_ok, d_last, d_intr;
  act_e                d_act;
  logic [LEN_W:0]      d_len;
  logic                cur_last, cur_intr;

  adma_desc_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk     (clk),
    .rst     (rst),
    .go      (fetch_go),
    .ptr     (ptr),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .rd_ack  (rd_ack),
    .rd_data (rd_data),
    .done    (f_done),
    .attr_q  (attr_q),
    .addr_q  (addr_q)
  );

  adma_desc_decode #(.LEN_W(LEN_W)) u_dec (
    .attr (attr_q),
    .ok   (d_ok),
    .last (d_last),
    .intr (d_intr),
    .act  (d_act),
    .len  (d_len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= W_IDLE;
      ptr       <= '0;
      fetch_go  <= 1'b0;
      busy      <= 1'b0;
      mv_valid  <= 1'b0;
      mv_addr   <= '0;
      mv_len    <= '0;
      irq_pulse <= 1'b0;
      err_pulse <= 1'b0;
      cur_last  <= 1'b0;
      cur_intr  <= 1'b0;
    end else begin
      fetch_go  <= 1'b0;
      irq_pulse <= 1'b0;
      err_pulse <= 1'b0;
      case (st)
        W_IDLE: if (start) begin
          ptr      <= base_addr;
          busy     <= 1'b1;
          fetch_go <= 1'b1;
          st       <= W_FETCH;
        end
        W_FETCH: if (f_done) begin
          if (!d_ok) begin
            err_pulse <= 1'b1;
            busy      <= 1'b0;
            st        <= W_IDLE;
          end else if (d_act == ACT_MOVE) begin
            mv_valid <= 1'b1;
            mv_addr  <= addr_q[ADDR_W-1:0];
            mv_len   <= d_len;
            cur_last <= d_last;
            cur_intr <= d_intr;
            st       <= W_MOVE;
          end else begin
            irq_pulse <= d_intr;
            ptr       <= (d_act == ACT_JUMP) ? addr_q[ADDR_W-1:0] : ptr + DESC_STEP;
            if (d_last) begin
              busy <= 1'b0;
              st   <= W_IDLE;
            end else begin
              fetch_go <= 1'b1;
            end
          end
        end
        W_MOVE: if (mv_done) begin
          mv_valid  <= 1'b0;
          irq_pulse <= cur_intr;
          ptr       <= ptr + DESC_STEP;
          if (cur_last) begin
            busy <= 1'b0;
            st   <= W_IDLE;
          end else begin
            fetch_go <= 1'b1;
            st       <= W_FETCH;
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  // R9
  no_read_in_move_chk: assert property (@(posedge clk) disable iff (rst)
    mv_valid |-> !rd_req);

  // R9
  move_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mv_valid && !mv_done) |=> (mv_valid && $stable(mv_addr) && $stable(mv_len)));

  // R8
  err_stops_chk: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> (!busy && !mv_valid && !irq_pulse));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!rd_req && !mv_valid));

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy && start) |=> (ptr == $past(ptr) || $past(f_done) || $past(mv_done)));
endmodule

// File: tb/adma_walk_tb.sv
module adma_walk_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] base_addr = '0;
  logic              rd_req;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_ack = 1'b0;
  logic [31:0]       rd_data = '0;
  logic              mv_valid;
  logic [ADDR_W-1:0] mv_addr;
  logic [LEN_W:0]    mv_len;
  logic              mv_done = 1'b0;
  logic              busy, irq_pulse, err_pulse;

  int checks = 0;
  int errors = 0;
  int irq_seen = 0;
  int err_seen = 0;
  bit finished = 0;

  logic [31:0] mem [0:255];
  logic [ADDR_W-1:0] q_addr[$];
  logic [LEN_W:0]    q_len[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  adma_walk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .mv_valid(mv_valid), .mv_addr(mv_addr), .mv_len(mv_len), .mv_done(mv_done),
    .busy(busy), .irq_pulse(irq_pulse), .err_pulse(err_pulse)
  );

  // word memory: one-cycle registered answer per request
  always @(posedge clk) begin
    rd_ack  <= rd_req && !rd_ack;
    rd_data <= mem[rd_addr[9:2]];
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit v, bit e, bit i, logic [1:0] act, logic [15:0] len);
    return {len, 10'b0, act, 1'b0, i, e, v};
  endfunction

  task automatic put(int byte_addr, logic [31:0] attr, logic [31:0] addr);
    mem[byte_addr >> 2]       = attr;
    mem[(byte_addr >> 2) + 1] = addr;
  endtask

  task automatic expect_move(logic [31:0] a, logic [LEN_W:0] l);
    q_addr.push_back(a);
    q_len.push_back(l);
  endtask

  // monitor and data-mover model
  initial begin
    bit pend = 0;
    int dly = 0;
    forever begin
      @(negedge clk);
      mv_done = 1'b0;
      if (irq_pulse) irq_seen++;
      if (err_pulse) err_seen++;
      if (mv_valid && rd_req) chk(0, "R9 read during transfer", 1, 0);
      if (mv_valid && !pend) begin
        if (q_addr.size() == 0) begin
          chk(0, "R2/R4/R5 unexpected transfer", mv_addr, 0);
        end else begin
          logic [31:0] ea;
          logic [LEN_W:0] el;
          ea = q_addr.pop_front();
          el = q_len.pop_front();
          chk(mv_addr == ea, "R2 transfer address", mv_addr, ea);
          chk(mv_len == el, "R2/R3 transfer length", mv_len, el);
        end
        pend = 1;
        dly = 3;
      end else if (pend) begin
        if (dly == 0) begin
          mv_done = 1'b1;
          pend = 0;
        end else begin
          dly--;
        end
      end
    end
  end

  task automatic run(int base, int exp_irq, int exp_err, string tag, bit restart);
    irq_seen = 0;
    err_seen = 0;
    @(negedge clk);
    base_addr = base;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {tag, " busy after start"}, busy, 1);
    if (restart) begin
      repeat (10) @(negedge clk);
      base_addr = 32'h0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(q_addr.size() == 0, {tag, " all transfers seen"}, q_addr.size(), 0);
    chk(irq_seen == exp_irq, {tag, " irq count (R7)"}, irq_seen, exp_irq);
    chk(err_seen == exp_err, {tag, " err count (R8)"}, err_seen, exp_err);
    q_addr.delete();
    q_len.delete();
  endtask

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = 32'h0;
    // chain A at 0x000: three transfers
    put(32'h000, mk(1,0,1,2'd2,16'd512),  32'h1000_0000);
    put(32'h008, mk(1,0,0,2'd2,16'd4096), 32'h2000_0000);
    put(32'h010, mk(1,1,1,2'd2,16'd8),    32'h3000_0000);
    // chain B at 0x040: skip, reserved, move, link to 0x100
    put(32'h040, mk(1,0,1,2'd0,16'd0),    32'hDEAD_0000);
    put(32'h048, mk(1,0,0,2'd1,16'd77),   32'hBEEF_0000);
    put(32'h050, mk(1,0,0,2'd2,16'd64),   32'h0A00_0040);
    put(32'h058, mk(1,0,0,2'd3,16'd0),    32'h0000_0100);
    put(32'h060, mk(1,1,1,2'd2,16'd99),   32'h0BAD_0000);
    put(32'h100, mk(1,1,0,2'd2,16'd0),    32'h0B00_0000);
    // chain C at 0x080: move then invalid
    put(32'h080, mk(1,0,0,2'd2,16'd16),   32'h0C00_0000);
    put(32'h088, mk(0,0,1,2'd2,16'd16),   32'h0C00_1000);
    // chain D at 0x0C0: move then skip with end
    put(32'h0C0, mk(1,0,1,2'd2,16'd32),   32'h0D00_0000);
    put(32'h0C8, mk(1,1,1,2'd0,16'd0),    32'h0000_0000);
    // chain E at 0x140: link with end
    put(32'h140, mk(1,1,0,2'd3,16'd0),    32'h0000_0000);
    // chain F at 0x180: reserved bit 3 set
    put(32'h180, mk(1,0,0,2'd2,16'd4) | 32'h8, 32'h0F00_0000);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11
    chk(!busy && !rd_req && !mv_valid && !irq_pulse && !err_pulse, "R11 reset state",
        {busy, rd_req, mv_valid, irq_pulse, err_pulse}, 0);

    // R1 R2 R6 R7: plain chain
    expect_move(32'h1000_0000, 17'd512);
    expect_move(32'h2000_0000, 17'd4096);
    expect_move(32'h3000_0000, 17'd8);
    run(32'h000, 2, 0, "R2 chainA", 0);

    // R3 R4 R5: skip, reserved action, link, zero length
    expect_move(32'h0A00_0040, 17'd64);
    expect_move(32'h0B00_0000, 17'h10000);
    run(32'h040, 1, 0, "R5 chainB", 0);

    // R8: invalid descriptor
    expect_move(32'h0C00_0000, 17'd16);
    run(32'h080, 0, 1, "R8 chainC", 0);

    // R10: restart pulse mid-chain ignored
    expect_move(32'h0D00_0000, 17'd32);
    run(32'h0C0, 2, 0, "R10 chainD", 1);

    // R6: end flag on link descriptor stops walker
    run(32'h140, 0, 0, "R6 chainE", 0);

    // R8: reserved bit set
    run(32'h180, 0, 1, "R8 chainF", 0);

    chk(!busy && !rd_req && !mv_valid, "R11 idle at end", busy, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule